// File: doc/BRIEF.md
# Iterative Binary Integer Square Root

This unit computes the integer square root of an unsigned operand of `OPW` bits (64 by default; 32-bit and other even widths come from the same parameter). It decides one root bit per clock. In each iteration it shifts the next operand bit pair into a partial remainder. It forms a trial value by doubling the partial root and appending a guessed 1. It subtracts that trial from the shifted remainder. The borrow out of the subtraction then selects, through a multiplexer, either the difference or the unchanged shifted remainder. The design has no multiplier, no divider and no add-back correction. Once a root bit has been decided, it is never revised.

A caller presents the operand together with a one-cycle `start` strobe while `busy` is low. The unit raises `busy`, runs `OPW/2` iterations and then pulses `done` for one cycle. During that cycle `root` and `remainder` carry the result, and they hold it until the next accepted start. The control is a three-state machine. `ST_IDLE` takes the accept transition to `ST_ITER` when `start` arrives. `ST_ITER` repeats until its last-iteration transition to `ST_DONE`. `ST_DONE` takes the retire transition back to `ST_IDLE` after one cycle.

Top module: `isqrt_unit`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `root` and `remainder` are 0.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high from the next cycle. `done` is high in exactly one cycle, which begins `OPW/2` + 1 rising edges after the accepting edge (so the accepting edge counts as 1). `busy` stays high through that cycle and is low in the cycle after it.
- R3: When `done` is high, `root` equals floor(sqrt(operand)) for the operand captured at acceptance.
- R4: When `done` is high, `remainder` equals operand − root², and at all times `remainder` ≤ 2·`root`.
- R5: A `start` sampled while `busy` is high has no effect: the running computation keeps its result and its timing, and no new computation begins after `done`.
- R6: Operand 0 gives root 0 and remainder 0. An all-ones operand gives root 2^(OPW/2)−1 and remainder 2^(OPW/2+1)−2. Every perfect square gives remainder 0.
- R7: Operand 93 gives root 9 and remainder 12.
- R8: While the unit is idle and no start is accepted, and in the cycle after `done`, `root` and `remainder` keep their values.
- R9: In each iteration cycle, the new `root` equals the previous `root` shifted left by one place with the newly decided bit at bit 0, so every earlier root bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a computation on `operand`; honoured only while `busy` is low |
| operand | input | OPW | Unsigned radicand, sampled with an accepted `start` |
| busy | output | 1 | High from acceptance through the `done` cycle |
| done | output | 1 | One-cycle pulse marking a valid result |
| root | output | OPW/2 | Integer square root (partial root during iterations) |
| remainder | output | OPW/2+2 | Operand minus root squared (partial during iterations) |

## Verification
The checker assumes that `start` is a clean synchronous level. It also assumes that `operand` only matters on the edge that accepts a start, because it captures the operand only there to confirm that root² + remainder reproduces it. The stimulus drives `start` and `operand` half a cycle away from the active edge. It pulses `start` for one cycle to begin each computation, and it raises `start` on purpose during iterations and during the `done` cycle to test that a start is ignored while busy. A 12-bit instance is swept over every operand. A 64-bit instance runs the corner values plus pseudo-random operands, near-squares and perfect squares. The result is checked against the identity and the bound, which together fix the root uniquely.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_DONE = 2'd2
    } isqrt_state_e;

endpackage

// File: rtl/isqrt_ctrl.sv
module isqrt_ctrl
    import isqrt_pkg::*;
#(
    parameter int ITERS = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);

    localparam int CNTW = $clog2(ITERS + 1);

    isqrt_state_e   state_q, state_d;
    logic [CNTW-1:0] iter_q;
    logic            last_iter;

    assign last_iter = (iter_q == CNTW'(ITERS - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    iter_q <= '0;
        else if (load) iter_q <= '0;
        else if (step) iter_q <= iter_q + CNTW'(1);
    end

    // transitions: accept, last iteration, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_ITER;
            ST_ITER: if (last_iter) state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        load = 1'b0;
        step = 1'b0;
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: load = start;
            ST_ITER: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_DONE: begin
                busy = 1'b1;
                done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/isqrt_trial.sv
module isqrt_trial #(
    parameter  int ROOTW = 32,
    localparam int REMW  = ROOTW + 2
) (
    input  logic [REMW-1:0]  rem_shifted,
    input  logic [ROOTW-1:0] root_so_far,
    output logic             bit_taken,
    output logic [REMW-1:0]  rem_next
);

    logic [REMW-1:0] guess;
    logic [REMW:0]   diff;

    // doubled partial root with a guessed 1 below it
    assign guess     = {root_so_far, 2'b01};
    assign diff      = {1'b0, rem_shifted} - {1'b0, guess};
    assign bit_taken = ~diff[REMW];
    assign rem_next  = bit_taken ? diff[REMW-1:0] : rem_shifted;

endmodule

// File: rtl/isqrt_datapath.sv
module isqrt_datapath #(
    parameter  int OPW   = 64,
    localparam int ROOTW = OPW / 2,
    localparam int REMW  = ROOTW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [OPW-1:0]   operand,
    output logic [ROOTW-1:0] root,
    output logic [REMW-1:0]  remainder
);

    logic [OPW-1:0]   pairs_q;
    logic [REMW-1:0]  rem_q;
    logic [ROOTW-1:0] root_q;
    logic [REMW-1:0]  rem_shifted;
    logic [REMW-1:0]  rem_next;
    logic             bit_taken;

    // bring in the next two most significant operand bits
    assign rem_shifted = {rem_q[REMW-3:0], pairs_q[OPW-1 -: 2]};

    isqrt_trial #(.ROOTW(ROOTW)) u_trial (
        .rem_shifted (rem_shifted),
        .root_so_far (root_q),
        .bit_taken   (bit_taken),
        .rem_next    (rem_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pairs_q <= '0;
            rem_q   <= '0;
            root_q  <= '0;
        end else if (load) begin
            pairs_q <= operand;
            rem_q   <= '0;
            root_q  <= '0;
        end else if (step) begin
            pairs_q <= {pairs_q[OPW-3:0], 2'b00};
            rem_q   <= rem_next;
            root_q  <= {root_q[ROOTW-2:0], bit_taken};
        end
    end

    assign root      = root_q;
    assign remainder = rem_q;

endmodule

// File: rtl/isqrt_unit.sv
module isqrt_unit #(
    parameter  int OPW   = 64,
    localparam int ROOTW = OPW / 2,
    localparam int REMW  = OPW / 2 + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OPW-1:0]   operand,
    output logic             busy,
    output logic             done,
    output logic [ROOTW-1:0] root,
    output logic [REMW-1:0]  remainder
);

    generate
        if ((OPW % 2) != 0 || OPW < 4) begin : g_bad_width
            $error("isqrt_unit: OPW must be even and at least 4");
        end
    endgenerate

    logic load;
    logic step;

    isqrt_ctrl #(.ITERS(ROOTW)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .step  (step),
        .busy  (busy),
        .done  (done)
    );

    isqrt_datapath #(.OPW(OPW)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .operand   (operand),
        .root      (root),
        .remainder (remainder)
    );

endmodule

// File: rtl/isqrt_unit_chk.sv
module isqrt_unit_chk #(
    parameter  int OPW   = 64,
    localparam int ROOTW = OPW / 2,
    localparam int REMW  = OPW / 2 + 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [OPW-1:0]   operand,
    input logic             busy,
    input logic             done,
    input logic [ROOTW-1:0] root,
    input logic [REMW-1:0]  remainder
);

    localparam int LATW = $clog2(ROOTW + 2) + 1;

    logic [LATW-1:0] lat_q;
    logic [OPW-1:0]  op_cap;
    logic [OPW+1:0]  recon;
    logic [REMW-1:0] twice_root;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q  <= '0;
            op_cap <= '0;
        end else if (start && !busy) begin
            lat_q  <= '0;
            op_cap <= operand;
        end else if (busy) begin
            lat_q  <= lat_q + LATW'(1);
        end
    end

    assign recon      = (OPW+2)'(root) * (OPW+2)'(root) + (OPW+2)'(remainder);
    assign twice_root = REMW'({root, 1'b0});

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == LATW'(ROOTW)));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (recon == (OPW+2)'(op_cap)));

    assert_rem_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (remainder <= twice_root));

    assert_no_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(root) && $stable(remainder)));

    assert_retire_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(root) && $stable(remainder)));

    assert_root_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (root[ROOTW-1:1] == $past(root[ROOTW-2:0])));

endmodule

bind isqrt_unit isqrt_unit_chk #(.OPW(OPW)) u_isqrt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .operand   (operand),
    .busy      (busy),
    .done      (done),
    .root      (root),
    .remainder (remainder)
);

// File: tb/test_isqrt_unit.sv
`timescale 1ns/1ps
module test_isqrt_unit;

    localparam int SW  = 12;
    localparam int SRW = SW / 2;
    localparam int SMW = SW / 2 + 2;
    localparam int WW  = 64;
    localparam int WRW = WW / 2;
    localparam int WMW = WW / 2 + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic           s_start = 1'b0;
    logic [SW-1:0]  s_operand = '0;
    logic           s_busy, s_done;
    logic [SRW-1:0] s_root;
    logic [SMW-1:0] s_rem;

    logic           w_start = 1'b0;
    logic [WW-1:0]  w_operand = '0;
    logic           w_busy, w_done;
    logic [WRW-1:0] w_root;
    logic [WMW-1:0] w_rem;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    isqrt_unit #(.OPW(SW)) i_isqrt_unit (
        .clk(clk), .rst_n(rst_n), .start(s_start), .operand(s_operand),
        .busy(s_busy), .done(s_done), .root(s_root), .remainder(s_rem)
    );

    isqrt_unit #(.OPW(WW)) i_isqrt_unit_wide (
        .clk(clk), .rst_n(rst_n), .start(w_start), .operand(w_operand),
        .busy(w_busy), .done(w_done), .root(w_root), .remainder(w_rem)
    );

    task automatic chk(input bit ok, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // start the small instance and wait for done; cycles counts the accepting edge as 1
    task automatic run_small(input logic [SW-1:0] op, output int cycles);
        @(negedge clk);
        s_start = 1'b1;
        s_operand = op;
        @(negedge clk);
        s_start = 1'b0;
        cycles = 1;
        while (!s_done && cycles < 100) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic run_wide(input logic [WW-1:0] op, output int cycles);
        @(negedge clk);
        w_start = 1'b1;
        w_operand = op;
        @(negedge clk);
        w_start = 1'b0;
        cycles = 1;
        while (!w_done && cycles < 200) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic wide_case(input logic [WW-1:0] op);
        int cyc;
        logic [127:0] r, m, recon;
        run_wide(op, cyc);
        chk(cyc == WRW + 1, "R2 wide latency", cyc, WRW + 1);
        r = 128'(w_root);
        m = 128'(w_rem);
        recon = r * r + m;
        chk(recon == 128'(op), "R3 wide root^2+rem equals operand", recon, 128'(op));
        chk(m <= 2 * r, "R4 wide rem bound", m, 2 * r);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int cyc;
        int er, em;
        logic [SRW-1:0] prev_root;
        logic [SRW-1:0] held_root;
        logic [SMW-1:0] held_rem;
        logic [WW-1:0]  x;
        logic [WW-1:0]  k;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(!s_busy && !s_done, "R1 small busy/done after reset", {s_busy, s_done}, 0);
        chk(s_root == 0 && s_rem == 0, "R1 small root/rem after reset", {s_root, s_rem}, 0);
        chk(!w_busy && !w_done, "R1 wide busy/done after reset", {w_busy, w_done}, 0);
        chk(w_root == 0 && w_rem == 0, "R1 wide root/rem after reset", {w_root, w_rem}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 operand 93, and R9 root bits kept each iteration
        @(negedge clk);
        s_start = 1'b1;
        s_operand = SW'(93);
        @(negedge clk);
        s_start = 1'b0;
        chk(s_busy, "R2 busy after accept", s_busy, 1);
        prev_root = s_root;
        cyc = 1;
        while (!s_done && cyc < 100) begin
            @(negedge clk);
            cyc++;
            chk((s_root >> 1) == prev_root, "R9 root shift keeps earlier bits", s_root, prev_root);
            prev_root = s_root;
        end
        chk(cyc == SRW + 1, "R2 latency", cyc, SRW + 1);
        chk(s_root == 9, "R7 root of 93", s_root, 9);
        chk(s_rem == 12, "R7 remainder of 93", s_rem, 12);
        @(negedge clk);
        chk(!s_done && !s_busy, "R2 done is one cycle", {s_busy, s_done}, 0);

        // R8 hold while idle
        held_root = s_root;
        held_rem = s_rem;
        repeat (5) @(negedge clk);
        chk(s_root == held_root && s_rem == held_rem, "R8 result held while idle",
            {s_root, s_rem}, {held_root, held_rem});

        // R5 start while busy is ignored, also during the done cycle
        @(negedge clk);
        s_start = 1'b1;
        s_operand = SW'(200);
        @(negedge clk);
        s_start = 1'b0;
        cyc = 1;
        while (!s_done && cyc < 100) begin
            if (cyc == 3) begin
                s_start = 1'b1;
                s_operand = '1;
            end else begin
                s_start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        chk(cyc == SRW + 1, "R5 latency unchanged by mid-run start", cyc, SRW + 1);
        chk(s_root == 14 && s_rem == 4, "R5 result of first operand kept", {s_root, s_rem}, {6'd14, 8'd4});
        s_start = 1'b1;
        s_operand = '1;
        @(negedge clk);
        s_start = 1'b0;
        chk(!s_busy && !s_done, "R5 start in done cycle does not restart", {s_busy, s_done}, 0);
        chk(s_root == 14 && s_rem == 4, "R8 result held after done", {s_root, s_rem}, {6'd14, 8'd4});

        // R3 R4 R6 exhaustive sweep of the small instance
        for (int op = 0; op < (1 << SW); op++) begin
            er = 0;
            while ((er + 1) * (er + 1) <= op) er++;
            em = op - er * er;
            run_small(SW'(op), cyc);
            chk(cyc == SRW + 1, "R2 sweep latency", cyc, SRW + 1);
            chk(int'(s_root) == er, $sformatf("R3 root of %0d", op), s_root, er);
            chk(int'(s_rem) == em, $sformatf("R4 remainder of %0d", op), s_rem, em);
            if (op == 0)
                chk(s_root == 0 && s_rem == 0, "R6 zero operand", {s_root, s_rem}, 0);
            if (op == (1 << SW) - 1)
                chk(int'(s_root) == (1 << SRW) - 1 && int'(s_rem) == (1 << (SRW + 1)) - 2,
                    "R6 all-ones operand", {s_root, s_rem},
                    {6'((1 << SRW) - 1), 8'((1 << (SRW + 1)) - 2)});
            if (em == 0 && er * er == op)
                chk(s_rem == 0, "R6 perfect square remainder", s_rem, 0);
            @(negedge clk);
        end

        // wide instance: corners
        wide_case('0);
        chk(w_root == 0 && w_rem == 0, "R6 wide zero", {w_root, w_rem}, 0);
        wide_case('1);
        chk(w_root == {WRW{1'b1}}, "R6 wide all-ones root", w_root, {WRW{1'b1}});
        chk(w_rem == WMW'(({WRW{1'b1}} * 2)), "R6 wide all-ones remainder", w_rem, WMW'({WRW{1'b1}} * 2));
        wide_case(WW'(93));
        chk(w_root == 9 && w_rem == 12, "R7 wide 93", {w_root, w_rem}, {32'd9, 34'd12});

        // wide instance: pseudo-random, perfect squares and their neighbours
        x = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 0; i < 24; i++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 7);
            x = x ^ (x << 17);
            wide_case(x);
            k = {32'd0, x[31:0]};
            wide_case(k * k);
            chk(w_rem == 0 && w_root == k[31:0], "R6 wide perfect square",
                {w_root, w_rem}, {k[31:0], 34'd0});
            if (k != 0) wide_case(k * k - 64'd1);
        end

        summary();
        $finish;
    end

endmodule